// File: doc/BRIEF.md
# Package Idle State Coordinator

This block watches the idle code that each of several cores reports. From those codes it picks a low-power state for the whole package. The package drops one level at a time, and only after every core has rested in its deepest core state for a programmable number of cycles. A software-set ceiling caps how deep the package may go. When any core becomes busy again, or asks to wake, the package returns to the active state. A wake indication then stays high for an exit time that grows with the depth of the state being left.

Coherency snoops are granted in the cycle after they arrive. In the shallower sleep states this happens without any change of state. In the deepest state, a snoop lifts the package only part of the way, to the intermediate PC2 level. Once the snoop is serviced there, the package either drops straight back or begins a new descent.

Top module: `pkg_idle_coord`

## Requirements
- R1: While reset is held and in the cycle after it is released, pkg_state is 0 (PC0), and snoop_grant and pkg_wake are 0.
- R2: Package state codes are PC0=0, PC1E=1, PC2=2 and PC6=3. Core codes are C0=0, C1=1, C1E=2 and C6=3, with core i at core_state[2i+1:2i]. While every core is C6, no wake_req bit is set and pkg_wake is low, the state goes one level deeper after dwell_limit+1 consecutive idle cycles at the current level. The state never rises by more than one level per cycle.
- R3: If any core is not C6, or any wake_req bit is set, pkg_state is PC0 on the next cycle.
- R4: Apart from the snoop wake of R6, pkg_state never goes deeper than depth_limit. If depth_limit is lowered below the current state while all cores are idle, the state moves to depth_limit on the next cycle and pkg_wake stays low.
- R5: snoop_grant is high in the cycle after any cycle in which snoop_req is high. A snoop in PC0, PC1E or PC2 does not change pkg_state.
- R6: A snoop that arrives in PC6 while all cores are idle moves the package to PC2. snoop_grant is high in that same cycle.
- R7: In the cycle after a PC6 snoop has been serviced in PC2, the package returns to PC6 if all cores are still idle and depth_limit is 3. Otherwise it stays in PC2 with a fresh dwell count.
- R8: On a return to PC0 from PC1E, PC2 or PC6, pkg_wake is high for exactly EXIT_PC1E, EXIT_PC2 or EXIT_PC6 cycles (default 2, 5 and 12), starting in the cycle after the exit. No pulse occurs if the package is already in PC0.
- R9: While pkg_wake is high, the package does not descend from PC0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_state | input | 2*N_CORES | Idle code of each core, 2 bits per core |
| wake_req | input | N_CORES | Per-core wake request; any set bit forces PC0 |
| snoop_req | input | 1 | Snoop arrival strobe |
| depth_limit | input | 2 | Deepest package state allowed |
| dwell_limit | input | DWELL_W | Dwell threshold per level, in cycles minus one |
| pkg_state | output | 2 | Current package state code |
| snoop_grant | output | 1 | Snoop serviced in this cycle |
| pkg_wake | output | 1 | Package exit in progress |

## Verification
A dwell or exit counter that is off by one shows up at the ports as a state step or the end of a wake pulse arriving one cycle early or late. The bench therefore checks every cycle of the descent and counts the exact length of each wake pulse. A stale snoop-return flag shows within one cycle, as a PC2-to-PC6 jump that should not happen, or a missing one. A wrong limit comparison shows as a state one level too deep on the cycle after the limit changes.

// File: rtl/pkg_idle_coord.sv
module pkg_idle_coord #(
  parameter int N_CORES   = 4,
  parameter int DWELL_W   = 8,
  parameter int EXIT_PC1E = 2,
  parameter int EXIT_PC2  = 5,
  parameter int EXIT_PC6  = 12,
  localparam int EXIT_W   = $clog2(EXIT_PC6 + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2*N_CORES-1:0]   core_state,
  input  logic [N_CORES-1:0]     wake_req,
  input  logic                   snoop_req,
  input  logic [1:0]             depth_limit,
  input  logic [DWELL_W-1:0]     dwell_limit,
  output logic [1:0]             pkg_state,
  output logic                   snoop_grant,
  output logic                   pkg_wake
);

  localparam logic [1:0] PC0 = 2'd0, PC2 = 2'd2, PC6 = 2'd3;

  logic [N_CORES-1:0] in_c6;
  logic               all_idle;
  logic [DWELL_W-1:0] dwell_q;
  logic [EXIT_W-1:0]  exit_q, exit_lat;
  logic               ret_q;

  for (genvar i = 0; i < N_CORES; i++) begin : g_core
    assign in_c6[i] = core_state[2*i +: 2] == 2'd3;
  end

  assign all_idle = (&in_c6) && !(|wake_req);
  assign pkg_wake = exit_q != '0;

  always_comb begin
    case (pkg_state)
      2'd1:    exit_lat = EXIT_W'(EXIT_PC1E);
      2'd2:    exit_lat = EXIT_W'(EXIT_PC2);
      2'd3:    exit_lat = EXIT_W'(EXIT_PC6);
      default: exit_lat = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkg_state   <= PC0;
      dwell_q     <= '0;
      exit_q      <= '0;
      ret_q       <= 1'b0;
      snoop_grant <= 1'b0;
    end else begin
      snoop_grant <= snoop_req;
      if (exit_q != '0) exit_q <= exit_q - 1'b1;
      if (!all_idle) begin
        dwell_q <= '0;
        ret_q   <= 1'b0;
        if (pkg_state != PC0) begin
          pkg_state <= PC0;
          exit_q    <= exit_lat;
        end
      end else if (pkg_state == PC6 && snoop_req) begin
        pkg_state <= PC2;
        ret_q     <= 1'b1;
        dwell_q   <= '0;
      end else if (pkg_state > depth_limit) begin
        pkg_state <= depth_limit;
        ret_q     <= 1'b0;
        dwell_q   <= '0;
      end else if (ret_q) begin
        ret_q   <= 1'b0;
        dwell_q <= '0;
        if (depth_limit == PC6) pkg_state <= PC6;
      end else if (pkg_state < depth_limit && exit_q == '0) begin
        if (dwell_q >= dwell_limit) begin
          pkg_state <= pkg_state + 2'd1;
          dwell_q   <= '0;
        end else begin
          dwell_q <= dwell_q + 1'b1;
        end
      end
    end
  end

  AST_BUSY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !all_idle |=> pkg_state == PC0); // R3
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> {1'b0, pkg_state} <= {1'b0, $past(pkg_state)} + 3'd1); // R2
  AST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkg_state == PC6 && snoop_req) |=> pkg_state <= $past(depth_limit)); // R4
  AST_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_req |=> snoop_grant); // R5
  AST_SNOOP_PC6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkg_state == PC6 && snoop_req && all_idle) |=> pkg_state == PC2); // R6
  AST_WAKE_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (pkg_state != PC0 && !all_idle) |=> pkg_wake); // R8
  AST_HOLD_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (pkg_wake && pkg_state == PC0) |=> pkg_state == PC0); // R9

endmodule

// File: tb/test_pkg_idle_coord.sv
module test_pkg_idle_coord;
  logic       clk = 0, rst_n = 0;
  logic [7:0] core_state = 8'h00;
  logic [3:0] wake_req = 4'h0;
  logic       snoop_req = 0;
  logic [1:0] depth_limit = 2'd3;
  logic [7:0] dwell_limit = 8'd2;
  logic [1:0] pkg_state;
  logic       snoop_grant, pkg_wake;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  pkg_idle_coord i_pkg_idle_coord (.clk, .rst_n, .core_state, .wake_req, .snoop_req,
    .depth_limit, .dwell_limit, .pkg_state, .snoop_grant, .pkg_wake);

  // {core[18:11], wake[10:7], snoop[6], limit[5:4], exp_state[3:2], exp_grant[1], exp_wake[0]}
  localparam logic [18:0] VEC [13] = '{
    {8'h00, 4'h0, 1'b0, 2'd3, 2'd0, 1'b0, 1'b0},
    {8'hFF, 4'h0, 1'b0, 2'd3, 2'd0, 1'b0, 1'b0},
    {8'hFF, 4'h0, 1'b0, 2'd3, 2'd0, 1'b0, 1'b0},
    {8'hFF, 4'h0, 1'b0, 2'd3, 2'd1, 1'b0, 1'b0},
    {8'hFF, 4'h0, 1'b1, 2'd3, 2'd1, 1'b1, 1'b0},
    {8'hFF, 4'h0, 1'b0, 2'd3, 2'd1, 1'b0, 1'b0},
    {8'hFF, 4'h0, 1'b0, 2'd3, 2'd2, 1'b0, 1'b0},
    {8'hFF, 4'h0, 1'b0, 2'd3, 2'd2, 1'b0, 1'b0},
    {8'hFF, 4'h0, 1'b0, 2'd3, 2'd2, 1'b0, 1'b0},
    {8'hFF, 4'h0, 1'b0, 2'd3, 2'd3, 1'b0, 1'b0},
    {8'hFF, 4'h0, 1'b1, 2'd3, 2'd2, 1'b1, 1'b0},
    {8'hFF, 4'h0, 1'b0, 2'd3, 2'd3, 1'b0, 1'b0},
    {8'hFD, 4'h0, 1'b0, 2'd3, 2'd0, 1'b0, 1'b1}
  };

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic reset_dut(input logic [7:0] dw, input logic [1:0] lim);
    rst_n = 0; core_state = 8'h00; wake_req = 0; snoop_req = 0;
    dwell_limit = dw; depth_limit = lim;
    tick; tick; rst_n = 1;
  endtask

  task automatic count_wake(input string tag, input int exp);
    int n = 0;
    for (int k = 0; k < 100 && pkg_wake; k++) begin n++; tick; end
    chk(tag, n, exp);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    reset_dut(8'd2, 2'd3);
    // R1 reset state
    chk("R1 state", pkg_state, 0); chk("R1 grant", snoop_grant, 0); chk("R1 wake", pkg_wake, 0);
    tick;
    chk("R1 state after release", pkg_state, 0);

    // R2 R5 R6 R7 R3 table walk
    for (int v = 0; v < 13; v++) begin
      core_state = VEC[v][18:11]; wake_req = VEC[v][10:7];
      snoop_req = VEC[v][6]; depth_limit = VEC[v][5:4];
      tick;
      chk($sformatf("R2/R5/R6/R7 vec%0d state", v), pkg_state, VEC[v][3:2]);
      chk($sformatf("R5/R6 vec%0d grant", v), snoop_grant, VEC[v][1]);
      chk($sformatf("R3/R8 vec%0d wake", v), pkg_wake, VEC[v][0]);
    end
    snoop_req = 0;
    count_wake("R8 PC6 exit length", 12);

    // R4 R8 R9 from PC1E
    reset_dut(8'd0, 2'd1);
    core_state = 8'hFF; tick;
    chk("R2 step dwell0", pkg_state, 1);
    tick;
    chk("R4 held at limit", pkg_state, 1);
    core_state = 8'h3F; tick;
    chk("R3 busy core", pkg_state, 0); chk("R8 wake start", pkg_wake, 1);
    core_state = 8'hFF; tick;
    chk("R9 hold st", pkg_state, 0); chk("R8 wake 2nd", pkg_wake, 1);
    tick;
    chk("R9 hold st end", pkg_state, 0); chk("R8 PC1E length", pkg_wake, 0);
    tick;
    chk("R9 resume", pkg_state, 1);

    // R8 from PC2
    reset_dut(8'd0, 2'd2);
    core_state = 8'hFF; tick; tick;
    chk("R2 reach PC2", pkg_state, 2);
    core_state = 8'hF3; tick;
    count_wake("R8 PC2 exit length", 5);

    // R4 lower limit, R7 stay in PC2, R3 wake_req
    reset_dut(8'd0, 2'd3);
    core_state = 8'hFF; tick; tick; tick;
    chk("R2 reach PC6", pkg_state, 3);
    depth_limit = 2'd1; tick;
    chk("R4 lowered limit", pkg_state, 1); chk("R4 no wake", pkg_wake, 0);
    depth_limit = 2'd3; tick; tick;
    chk("R2 back to PC6", pkg_state, 3);
    depth_limit = 2'd2; snoop_req = 1; tick;
    snoop_req = 0;
    chk("R6 snoop PC2", pkg_state, 2); chk("R6 grant", snoop_grant, 1);
    tick;
    chk("R7 stays PC2", pkg_state, 2); chk("R7 grant off", snoop_grant, 0);
    depth_limit = 2'd3; tick;
    chk("R7 descent resumes", pkg_state, 3);
    wake_req = 4'h4; tick;
    chk("R3 wake_req", pkg_state, 0);
    wake_req = 4'h0; core_state = 8'h00;
    count_wake("R8 wake_req exit", 12);

    // R5 snoop in PC0 and no pulse when already PC0
    snoop_req = 1; tick; snoop_req = 0;
    chk("R5 grant PC0", snoop_grant, 1); chk("R5 state PC0", pkg_state, 0);
    chk("R8 no pulse in PC0", pkg_wake, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule